// File: doc/BRIEF.md
# Transfer Length Counter with DMA Completion Reporting

This block holds the byte count that software programs for a DMA transfer between memory and a storage target. The count is written as two byte-wide registers. When a transfer-information command starts, the block works out how many bytes the transfer will actually move, then counts that length down as the DMA engine reports the bytes it has moved. When the transfer ends it raises completion. Completion sets the terminal-count status flag, loads the bus-service interrupt code, clears the programmed count and raises the interrupt line.

The length is the programmed count, where a programmed zero means 65536 bytes. It is then clipped. In command phase the limit is 32 bytes. Otherwise the limit is the magnitude of the signed byte count that the target side still holds, and the sign of that count gives the direction. Completion is either raised at once or deferred until the target side reports that it has finished. The choice depends on how each beat left the target-side buffer.

Top module: `dma_xfer_counter`

## Requirements
- R1: The programmed count is `{hi byte, lo byte}`. A write with `cnt_wr_hi`=1 loads bits 15:8 and a write with `cnt_wr_hi`=0 loads bits 7:0. At a start, a programmed count of zero gives a length of 65536.
- R2: A start with `cmd_phase`=1 loads `remaining` with the smaller of the programmed length and 32, and sets `to_target` to 0.
- R3: A start with `cmd_phase`=0 loads `remaining` with the smaller of the programmed length and |`tgt_remain`|. It sets `to_target` to 1 exactly when `tgt_remain` is negative. If the length is zero the block stays idle (`busy`=0).
- R4: A start clears `tc_status`. A write to either count byte also clears `tc_status`.
- R5: Each `beat_valid` cycle in the running state lowers `remaining` by the smaller of `beat_bytes` and `remaining`, so the count never goes below zero.
- R6: Completion drives `done` high for exactly one cycle. In that same cycle it sets `tc_status`, loads `intr_code` with 0x10, clears `count_reg` and raises `irq`.
- R7: A beat with `beat_buf_empty`=0 (target buffer only partly used) completes the transfer in the next cycle.
- R8: Consider a beat with `beat_buf_empty`=1 that brings `remaining` to zero. It completes the transfer at once only if the transfer is from the target (`to_target`=0) and `tgt_more`=1. Otherwise the block waits, ignoring further beats, until `tgt_finish` completes the transfer. `tgt_finish` also completes a running transfer.
- R9: A start during a running or waiting transfer drops the old transfer with no `done` and loads the new length.
- R10: `irq_ack` clears `irq` and `intr_code`. A completion in the same cycle takes priority.
- R11: After reset all outputs are zero and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr_en | input | 1 | Write strobe for one count byte |
| cnt_wr_hi | input | 1 | 1 selects the high count byte, 0 the low byte |
| cnt_wr_data | input | 8 | Count byte value |
| start | input | 1 | Transfer-information command strobe |
| cmd_phase | input | 1 | Transfer carries command bytes |
| tgt_remain | input | REM_W | Signed byte count still held by the target side; negative means toward the target |
| tgt_more | input | 1 | Target still has data to deliver |
| beat_valid | input | 1 | DMA engine moved bytes this cycle |
| beat_bytes | input | BEAT_W | Bytes moved by this beat |
| beat_buf_empty | input | 1 | This beat drained the target-side buffer |
| tgt_finish | input | 1 | Target side finished its part |
| irq_ack | input | 1 | Interrupt acknowledge |
| remaining | output | CNT_W+1 | Bytes left in the transfer |
| to_target | output | 1 | Direction of the current transfer |
| busy | output | 1 | Transfer running or waiting |
| done | output | 1 | One-cycle completion event |
| tc_status | output | 1 | Terminal-count status flag |
| intr_code | output | 8 | Interrupt cause register |
| irq | output | 1 | Interrupt line |
| count_reg | output | CNT_W | Programmed count registers |

## Verification
Some properties are checked by assertions on every cycle. A completion always carries the full report: status flag, interrupt code, cleared count and raised line. The count never rises while a transfer runs. A start never produces a completion. A loaded length never exceeds 65536, 32 in command phase, or the target magnitude. Other behaviour shows up only in the bench's scenarios, where a cycle-level model is compared against the outputs. These are the choice between immediate and deferred completion after a drained buffer, the per-beat clamping amounts, the zero-means-65536 rule and the priority of completion over acknowledge.

// File: rtl/xfer_cnt_pkg.sv
package xfer_cnt_pkg;

    localparam int DEF_CNT_W   = 16;
    localparam int DEF_REM_W   = 24;
    localparam int DEF_BEAT_W  = 4;
    localparam int DEF_CMD_MAX = 32;

    localparam logic [7:0] INTR_BUS_SERVICE = 8'h10;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_RUN  = 2'd1,
        XS_HOLD = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic valid;
        logic buf_empty;
        logic more;
        logic finish;
    } beat_ev_t;

endpackage

// File: rtl/xfer_len_calc.sv
module xfer_len_calc
    import xfer_cnt_pkg::*;
#(
    parameter int CNT_W   = DEF_CNT_W,
    parameter int REM_W   = DEF_REM_W,
    parameter int CMD_MAX = DEF_CMD_MAX
) (
    input  logic [CNT_W-1:0] prog_count,
    input  logic             cmd_phase,
    input  logic [REM_W-1:0] tgt_remain,
    output logic [CNT_W:0]   xfer_len,
    output logic             dir_to_tgt
);
    localparam int LEN_W = CNT_W + 1;

    logic [LEN_W-1:0] base_len;
    logic [REM_W-1:0] tgt_mag;

    always_comb begin
        // programmed zero stands for the full 2^CNT_W bytes
        base_len = (prog_count == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, prog_count};
        tgt_mag  = tgt_remain[REM_W-1] ? (~tgt_remain + REM_W'(1)) : tgt_remain;
        if (cmd_phase) begin
            xfer_len   = (base_len < LEN_W'(CMD_MAX)) ? base_len : LEN_W'(CMD_MAX);
            dir_to_tgt = 1'b0;
        end else begin
            xfer_len   = ({{(REM_W-LEN_W){1'b0}}, base_len} <= tgt_mag) ? base_len
                                                                         : tgt_mag[LEN_W-1:0];
            dir_to_tgt = tgt_remain[REM_W-1];
        end
    end
endmodule

// File: rtl/xfer_down_counter.sv
module xfer_down_counter
    import xfer_cnt_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int BEAT_W = DEF_BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W:0]    load_len,
    input  logic              load_dir,
    input  beat_ev_t          ev,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic [CNT_W:0]    remaining,
    output logic              to_target,
    output logic              busy,
    output logic              finish
);
    localparam int LEN_W = CNT_W + 1;

    xfer_state_e      state_q;
    logic [LEN_W-1:0] rem_q;
    logic             dir_q;
    logic [LEN_W-1:0] beat_ext;
    logic [LEN_W-1:0] dec_amt;
    logic [LEN_W-1:0] rem_next;
    logic             beat_take;
    logic             drained_zero;

    always_comb begin
        beat_ext     = {{(LEN_W-BEAT_W){1'b0}}, beat_bytes};
        dec_amt      = (beat_ext > rem_q) ? rem_q : beat_ext;
        rem_next     = rem_q - dec_amt;
        beat_take    = !start && (state_q == XS_RUN) && ev.valid;
        drained_zero = ev.buf_empty && (rem_next == '0);
        finish       = !start && (state_q != XS_IDLE) &&
                       (ev.finish ||
                        (beat_take && (!ev.buf_empty || (drained_zero && !dir_q && ev.more))));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_IDLE;
            rem_q   <= '0;
            dir_q   <= 1'b0;
        end else if (start) begin
            rem_q   <= load_len;
            dir_q   <= load_dir;
            state_q <= (load_len != '0) ? XS_RUN : XS_IDLE;
        end else begin
            if (beat_take)
                rem_q <= rem_next;
            if (finish)
                state_q <= XS_IDLE;
            else if (beat_take && drained_zero)
                state_q <= XS_HOLD;
        end
    end

    assign remaining = rem_q;
    assign to_target = dir_q;
    assign busy      = (state_q != XS_IDLE);

    // R5: the count never climbs while a transfer is in progress
    assert_no_climb_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (rem_q <= $past(rem_q)));

    // R9: a restart never reports a completion
    assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        start |-> !finish);

    // R8: a waiting transfer ignores beats
    assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == XS_HOLD && !start) |=> $stable(rem_q));
endmodule

// File: rtl/xfer_report.sv
module xfer_report
    import xfer_cnt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_wr_en,
    input  logic             cnt_wr_hi,
    input  logic [7:0]       cnt_wr_data,
    input  logic             start,
    input  logic             finish,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] count_reg,
    output logic             tc_status,
    output logic [7:0]       intr_code,
    output logic             irq,
    output logic             done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count_reg <= '0;
            tc_status <= 1'b0;
            intr_code <= '0;
            irq       <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                count_reg <= '0;
                tc_status <= 1'b1;
                intr_code <= INTR_BUS_SERVICE;
                irq       <= 1'b1;
            end else begin
                if (cnt_wr_en) begin
                    if (cnt_wr_hi)
                        count_reg[CNT_W-1:8] <= cnt_wr_data[CNT_W-9:0];
                    else
                        count_reg[7:0] <= cnt_wr_data;
                end
                if (cnt_wr_en || start)
                    tc_status <= 1'b0;
                if (irq_ack) begin
                    intr_code <= '0;
                    irq       <= 1'b0;
                end
            end
        end
    end

    // R6: every completion event carries the full report
    assert_done_report_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (tc_status && irq && intr_code == INTR_BUS_SERVICE && count_reg == '0));

    // R10: completion wins over a same-cycle acknowledge
    assert_ack_priority_R10: assert property (@(posedge clk) disable iff (rst)
        (finish && irq_ack) |=> irq);
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter
    import xfer_cnt_pkg::*;
#(
    parameter int CNT_W   = DEF_CNT_W,
    parameter int REM_W   = DEF_REM_W,
    parameter int BEAT_W  = DEF_BEAT_W,
    parameter int CMD_MAX = DEF_CMD_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_wr_en,
    input  logic              cnt_wr_hi,
    input  logic [7:0]        cnt_wr_data,
    input  logic              start,
    input  logic              cmd_phase,
    input  logic [REM_W-1:0]  tgt_remain,
    input  logic              tgt_more,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    input  logic              beat_buf_empty,
    input  logic              tgt_finish,
    input  logic              irq_ack,
    output logic [CNT_W:0]    remaining,
    output logic              to_target,
    output logic              busy,
    output logic              done,
    output logic              tc_status,
    output logic [7:0]        intr_code,
    output logic              irq,
    output logic [CNT_W-1:0]  count_reg
);
    localparam int LEN_W = CNT_W + 1;

    logic [LEN_W-1:0] len_w;
    logic             dir_w;
    logic             finish_w;
    beat_ev_t         ev_w;

    assign ev_w = '{valid: beat_valid, buf_empty: beat_buf_empty,
                    more: tgt_more, finish: tgt_finish};

    xfer_len_calc #(.CNT_W(CNT_W), .REM_W(REM_W), .CMD_MAX(CMD_MAX)) u_len (
        .prog_count (count_reg),
        .cmd_phase  (cmd_phase),
        .tgt_remain (tgt_remain),
        .xfer_len   (len_w),
        .dir_to_tgt (dir_w)
    );

    xfer_down_counter #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .load_len   (len_w),
        .load_dir   (dir_w),
        .ev         (ev_w),
        .beat_bytes (beat_bytes),
        .remaining  (remaining),
        .to_target  (to_target),
        .busy       (busy),
        .finish     (finish_w)
    );

    xfer_report #(.CNT_W(CNT_W)) u_rep (
        .clk         (clk),
        .rst         (rst),
        .cnt_wr_en   (cnt_wr_en),
        .cnt_wr_hi   (cnt_wr_hi),
        .cnt_wr_data (cnt_wr_data),
        .start       (start),
        .finish      (finish_w),
        .irq_ack     (irq_ack),
        .count_reg   (count_reg),
        .tc_status   (tc_status),
        .intr_code   (intr_code),
        .irq         (irq),
        .done        (done)
    );

    // R1: no loaded length exceeds the full-range count
    assert_len_cap_R1: assert property (@(posedge clk) disable iff (rst)
        start |=> (remaining <= {1'b1, {CNT_W{1'b0}}}));

    // R2: command-phase transfers are capped
    assert_cmd_cap_R2: assert property (@(posedge clk) disable iff (rst)
        (start && cmd_phase) |=> (remaining <= LEN_W'(CMD_MAX) && !to_target));

    // R3: a transfer from the target never exceeds what the target holds
    assert_tgt_clip_R3: assert property (@(posedge clk) disable iff (rst)
        (start && !cmd_phase && !tgt_remain[REM_W-1])
            |=> ({{(REM_W-LEN_W){1'b0}}, remaining} <= $past(tgt_remain)));

    // R4: a start leaves the terminal-count flag low
    assert_start_clears_tc_R4: assert property (@(posedge clk) disable iff (rst)
        start |=> !tc_status);
endmodule

// File: tb/tb_dma_xfer_counter.sv
module tb_dma_xfer_counter;
    localparam int CNT_W  = 16;
    localparam int REM_W  = 24;
    localparam int BEAT_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnt_wr_en = 0, cnt_wr_hi = 0;
    logic [7:0] cnt_wr_data = 0;
    logic start = 0, cmd_phase = 0, tgt_more = 0;
    logic signed [REM_W-1:0] tgt_remain = 0;
    logic beat_valid = 0, beat_buf_empty = 0, tgt_finish = 0, irq_ack = 0;
    logic [BEAT_W-1:0] beat_bytes = 0;
    logic [CNT_W:0] remaining;
    logic to_target, busy, done, tc_status, irq;
    logic [7:0] intr_code;
    logic [CNT_W-1:0] count_reg;

    always #2.5 clk = ~clk;

    dma_xfer_counter dut (
        .clk(clk), .rst(rst), .cnt_wr_en(cnt_wr_en), .cnt_wr_hi(cnt_wr_hi),
        .cnt_wr_data(cnt_wr_data), .start(start), .cmd_phase(cmd_phase),
        .tgt_remain(tgt_remain), .tgt_more(tgt_more), .beat_valid(beat_valid),
        .beat_bytes(beat_bytes), .beat_buf_empty(beat_buf_empty),
        .tgt_finish(tgt_finish), .irq_ack(irq_ack), .remaining(remaining),
        .to_target(to_target), .busy(busy), .done(done), .tc_status(tc_status),
        .intr_code(intr_code), .irq(irq), .count_reg(count_reg)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit cmp_on = 0;
    bit finished = 0;

    // behavioural reference model
    int m_state = 0, m_rem = 0, m_cnt = 0, m_intr = 0;
    bit m_dir = 0, m_tc = 0, m_irq = 0, m_done = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_rem = 0; m_dir = 0; m_cnt = 0;
            m_tc = 0; m_intr = 0; m_irq = 0; m_done = 0;
        end else begin
            bit fin;
            int prog, len, mag, t, d;
            fin = 0;
            prog = m_cnt;
            t = int'(tgt_remain);
            if (start) begin
                len = (prog == 0) ? 65536 : prog;
                if (cmd_phase) len = (len < 32) ? len : 32;
                else begin
                    mag = (t < 0) ? -t : t;
                    len = (len < mag) ? len : mag;
                end
                m_rem = len;
                m_dir = !cmd_phase && (t < 0);
                m_state = (len > 0) ? 1 : 0;
            end else if (m_state != 0) begin
                if (m_state == 1 && beat_valid) begin
                    d = (int'(beat_bytes) < m_rem) ? int'(beat_bytes) : m_rem;
                    m_rem = m_rem - d;
                end
                if (tgt_finish) fin = 1;
                else if (m_state == 1 && beat_valid) begin
                    if (!beat_buf_empty) fin = 1;
                    else if (m_rem == 0) begin
                        if (!m_dir && tgt_more) fin = 1;
                        else m_state = 2;
                    end
                end
                if (fin) m_state = 0;
            end
            if (cnt_wr_en) begin
                if (cnt_wr_hi) m_cnt = (m_cnt & 'hff) | (int'(cnt_wr_data) << 8);
                else m_cnt = (m_cnt & 'hff00) | int'(cnt_wr_data);
                m_tc = 0;
            end
            if (start) m_tc = 0;
            if (irq_ack) begin m_intr = 0; m_irq = 0; end
            if (fin) begin m_tc = 1; m_intr = 16; m_irq = 1; m_cnt = 0; end
            m_done = fin;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk(int'(remaining) == m_rem, "R5 model remaining", int'(remaining), m_rem);
            chk(to_target == m_dir, "R3 model to_target", int'(to_target), int'(m_dir));
            chk(busy == (m_state != 0), "R8 model busy", int'(busy), int'(m_state != 0));
            chk(done == m_done, "R6 model done", int'(done), int'(m_done));
            chk(tc_status == m_tc, "R4 model tc_status", int'(tc_status), int'(m_tc));
            chk(int'(intr_code) == m_intr, "R10 model intr_code", int'(intr_code), m_intr);
            chk(irq == m_irq, "R10 model irq", int'(irq), int'(m_irq));
            chk(int'(count_reg) == m_cnt, "R1 model count_reg", int'(count_reg), m_cnt);
        end
    end

    task automatic wr_cnt(input bit hi, input int val);
        @(negedge clk);
        cnt_wr_en = 1; cnt_wr_hi = hi; cnt_wr_data = 8'(val);
        @(negedge clk);
        cnt_wr_en = 0;
    endtask

    task automatic go(input bit cmd, input int t);
        @(negedge clk);
        start = 1; cmd_phase = cmd; tgt_remain = REM_W'(t);
        @(negedge clk);
        start = 0; cmd_phase = 0;
    endtask

    task automatic beat(input int n, input bit empty, input bit more);
        @(negedge clk);
        beat_valid = 1; beat_bytes = BEAT_W'(n); beat_buf_empty = empty; tgt_more = more;
        @(negedge clk);
        beat_valid = 0; beat_buf_empty = 0; tgt_more = 0;
    endtask

    task automatic fin_tgt(input bit ack);
        @(negedge clk);
        tgt_finish = 1; irq_ack = ack;
        @(negedge clk);
        tgt_finish = 0; irq_ack = 0;
    endtask

    task automatic ack_irq();
        @(negedge clk);
        irq_ack = 1;
        @(negedge clk);
        irq_ack = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cmp_on = 1;
        @(negedge clk);
        // R11 reset state
        chk(remaining == 0 && !busy && !done && !irq && count_reg == 0 && !tc_status,
            "R11 reset state", int'(busy), 0);

        // from-target transfer, drained buffer, target still has data
        wr_cnt(0, 5);
        go(0, 100);
        chk(remaining == 5 && !to_target && busy, "R3 clip to count", int'(remaining), 5);
        beat(2, 1, 1);
        chk(remaining == 3 && !done, "R5 beat decrement", int'(remaining), 3);
        beat(2, 1, 1);
        beat(3, 1, 1);
        chk(remaining == 0 && done, "R8 immediate completion", int'(done), 1);
        chk(tc_status && intr_code == 8'h10 && irq && count_reg == 0,
            "R6 completion report", int'(intr_code), 16);
        @(negedge clk);
        chk(!done, "R6 single cycle done", int'(done), 0);
        ack_irq();

        // zero count means full range, then restart in command phase
        go(0, 200000);
        chk(remaining == 65536, "R1 zero count full range", int'(remaining), 65536);
        chk(!tc_status, "R4 start clears tc", int'(tc_status), 0);
        go(1, 200000);
        chk(remaining == 32 && !done && busy, "R9 restart no done", int'(remaining), 32);
        chk(remaining == 32, "R2 command cap", int'(remaining), 32);
        fin_tgt(0);
        chk(done, "R8 finish completes running", int'(done), 1);

        // count write clears tc; toward-target, partial buffer
        wr_cnt(0, 'h40);
        chk(!tc_status, "R4 write clears tc", int'(tc_status), 0);
        wr_cnt(1, 'h01);
        chk(count_reg == 16'h0140, "R1 byte assembly", int'(count_reg), 'h140);
        go(0, -50);
        chk(remaining == 50 && to_target, "R3 negative clip", int'(remaining), 50);
        beat(4, 0, 0);
        chk(done && remaining == 46, "R7 partial buffer completes", int'(done), 1);
        ack_irq();
        chk(!irq && intr_code == 0, "R10 ack clears", int'(irq), 0);

        // toward target, drained to zero: completion deferred
        wr_cnt(1, 0);
        wr_cnt(0, 10);
        go(0, -10);
        beat(7, 1, 1);
        chk(remaining == 3 && busy && !done, "R5 partial count", int'(remaining), 3);
        beat(7, 1, 1);
        chk(remaining == 0 && !done && busy, "R5 clamp at zero", int'(remaining), 0);
        beat(5, 1, 1);
        chk(!done && busy, "R8 hold ignores beat", int'(done), 0);
        fin_tgt(1);
        chk(done && irq, "R10 completion beats ack", int'(irq), 1);
        ack_irq();

        // from target, drained, no more data: deferred
        wr_cnt(0, 8);
        go(0, 100);
        beat(15, 1, 0);
        chk(remaining == 0 && !done && busy, "R8 deferred without more", int'(done), 0);
        fin_tgt(0);
        chk(done, "R8 finish releases hold", int'(done), 1);

        // zero-length start stays idle
        wr_cnt(0, 8);
        go(0, 0);
        chk(!busy && remaining == 0, "R3 zero length idle", int'(busy), 0);
        repeat (3) @(negedge clk);
        summary();
    end
endmodule